// File: doc/BRIEF.md
# Slot event interrupt locator

This block collects hot-plug slot events and a command-completion flag into one interrupt. Each slot keeps a five-bit event latch. The latch bits are set by one-cycle pulses from the slot logic and are cleared by software writing ones. Each slot also has an eight-bit mask byte. A small control word holds four disable bits. The command-completion flag is set by a pulse from the command engine.

From this state the block computes, every cycle and without registers, a 32-bit locator word. Bit 0 of that word flags command completion. Bit s+1 flags slot s. The block drives a level interrupt from the locator. When message mode is on, it also raises a one-cycle message request each time the interrupt level moves away from the last recorded level.

A read port selects one slot and returns its latch and mask, so software can find the cause of an interrupt and clear it.

Top module: `slot_irq_locator`

## Requirements
- R1: While reset is asserted and right after it, the outputs hold these values: every event latch is 0, every mask is 0x7F, the control word is 0xF, the command flag is 0, the locator is 0, the interrupt level is 0 and the message request is 0.
- R2: A pulse on `evt_set_i[s*5+b]` sets latch bit b of slot s at the next edge. The bit then stays set until it is cleared. The bit meanings are: 0 presence change, 1 isolated power fault, 2 attention button, 3 retention-latch change, 4 connected power fault.
- R3: A clear write (`clr_en_i`) to slot `clr_slot_i` clears exactly the latch bits that are 1 in `clr_bits_i`. If a set pulse and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: A mask write stores all eight bits of `msk_data_i` for slot `msk_slot_i`. Only mask bits 4:0 gate the locator. Bits 5 and 6 are stored but have no effect on the locator.
- R5: Locator bit s+1 is 1 exactly when slot s has a latched event whose mask bit is 0. Locator bits above NUM_SLOTS are always 0.
- R6: Locator bit 0 equals (command flag AND NOT control bit 2).
  - A `cmd_done_i` pulse sets the command flag.
  - A control write with `ctl_data_i[4]`=1 clears the flag.
  - If a set and a clear arrive in the same cycle, the flag ends up set.
- R7: A control write loads `ctl_data_i[3:0]` into the control word. The bits are: 0 interrupt disable, 1 error disable, 2 command-interrupt disable, 3 arbiter-error disable.
- R8: `irq_level_o` is 1 exactly when control bit 0 is 0 and the locator is nonzero. It follows the register state in the same cycle.
- R9: If, at an edge, message mode is on and the current level differs from the recorded level, `msg_req_o` is 1 for the following cycle. The recorded level takes the current level at every edge.
- R10: While `msg_en_i` is 0, no message request is raised. Level changes in that period are still recorded, so turning message mode on later does not raise a request for them.
- R11: A write or read that names a slot index at or above NUM_SLOTS changes nothing, and such a read returns zero latch and mask values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | NUM_SLOTS*5 | Per-slot event set pulses, slot s at bits s*5+4:s*5 |
| cmd_done_i | input | 1 | Command-completion set pulse |
| clr_en_i | input | 1 | Latch clear-write strobe |
| clr_slot_i | input | SLOT_W | Slot addressed by the clear write |
| clr_bits_i | input | 5 | Write-one-to-clear bits |
| msk_en_i | input | 1 | Mask write strobe |
| msk_slot_i | input | SLOT_W | Slot addressed by the mask write |
| msk_data_i | input | 8 | Mask byte |
| ctl_en_i | input | 1 | Control write strobe |
| ctl_data_i | input | 5 | Disable bits [3:0], command-flag clear [4] |
| msg_en_i | input | 1 | Message mode enable |
| rd_slot_i | input | SLOT_W | Slot selected for readback |
| rd_latch_o | output | 5 | Event latch of the selected slot |
| rd_mask_o | output | 8 | Mask byte of the selected slot |
| ctl_o | output | 4 | Control word |
| locator_o | output | LOC_W | Interrupt locator word |
| irq_level_o | output | 1 | Level interrupt |
| msg_req_o | output | 1 | One-cycle message request |

## Verification
A corrupted latch or mask bit shows up in the locator and the interrupt level in the same cycle. The slot readback exposes it by the next cycle at the latest. A wrong recorded level is harder to see. It only shows as a missing or extra message pulse one cycle after the next level change, or after message mode is switched on. For that reason the stimulus toggles the interrupt level often while message mode is both on and off. The same-cycle set and clear cases are driven on purpose, because random traffic alone seldom lines them up.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
   localparam int EVT_W        = 5;
   localparam int MSK_W        = 8;
   localparam int CTL_W        = 4;
   localparam int CTL_INT_DIS  = 0;
   localparam int CTL_ERR_DIS  = 1;
   localparam int CTL_CMD_DIS  = 2;
   localparam int CTL_ARB_DIS  = 3;
   localparam int CTL_CMD_CLR  = 4;
   localparam logic [MSK_W-1:0] MASK_RST = 8'h7F;
   localparam logic [CTL_W-1:0] CTL_RST  = 4'hF;

   typedef enum logic [2:0] {
      EV_PRESENCE   = 3'd0,
      EV_ISO_FAULT  = 3'd1,
      EV_BUTTON     = 3'd2,
      EV_RETAIN     = 3'd3,
      EV_CONN_FAULT = 3'd4
   } evt_bit_e;
endpackage

// File: rtl/slot_evt_cell.sv
module slot_evt_cell #(
   parameter int EVT_W = 5,
   parameter int MSK_W = 8,
   parameter logic [MSK_W-1:0] MSK_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] set_i,
   input  logic             clr_en_i,
   input  logic [EVT_W-1:0] clr_bits_i,
   input  logic             msk_en_i,
   input  logic [MSK_W-1:0] msk_data_i,
   output logic [EVT_W-1:0] latch_o,
   output logic [MSK_W-1:0] mask_o,
   output logic             pend_o
);
   logic [EVT_W-1:0] latch_q;
   logic [MSK_W-1:0] mask_q;
   logic [EVT_W-1:0] clr_vec;

   if (EVT_W > MSK_W) begin : g_bad_width
      $error("slot_evt_cell: mask narrower than event latch");
   end

   assign clr_vec = clr_en_i ? clr_bits_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         mask_q  <= MSK_RST;
      end else begin
         latch_q <= (latch_q & ~clr_vec) | set_i;
         if (msk_en_i) mask_q <= msk_data_i;
      end
   end

   assign latch_o = latch_q;
   assign mask_o  = mask_q;
   assign pend_o  = |(latch_q & ~mask_q[EVT_W-1:0]);

   for (genvar b = 0; b < EVT_W; b++) begin : g_bit_chk
      p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> latch_q[b]);
      p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en_i && clr_bits_i[b] && !set_i[b]) |=> !latch_q[b]);
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[b] && !(clr_en_i && clr_bits_i[b])) |=> (latch_q[b] == $past(latch_q[b])));
   end

   p_mask_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      msk_en_i |=> (mask_q == $past(msk_data_i)));
endmodule

// File: rtl/cmd_ctl_reg.sv
module cmd_ctl_reg #(
   parameter int CTL_W = 4,
   parameter int CLR_BIT = 4,
   parameter logic [CTL_W-1:0] CTL_RST = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ctl_en_i,
   input  logic [CTL_W:0] ctl_data_i,
   input  logic           cmd_done_i,
   output logic [CTL_W-1:0] ctl_o,
   output logic           cmd_flag_o
);
   logic [CTL_W-1:0] ctl_q;
   logic             cmd_q;
   logic             cmd_clr;

   if (CLR_BIT != CTL_W) begin : g_bad_clr
      $error("cmd_ctl_reg: clear bit must sit just above the control bits");
   end

   assign cmd_clr = ctl_en_i && ctl_data_i[CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RST;
         cmd_q <= 1'b0;
      end else begin
         if (ctl_en_i) ctl_q <= ctl_data_i[CTL_W-1:0];
         cmd_q <= (cmd_q && !cmd_clr) || cmd_done_i;
      end
   end

   assign ctl_o      = ctl_q;
   assign cmd_flag_o = cmd_q;

   p_cmd_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done_i |=> cmd_flag_o);
   p_cmd_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_clr && !cmd_done_i) |=> !cmd_flag_o);
   p_ctl_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_en_i |=> (ctl_o == $past(ctl_data_i[CTL_W-1:0])));
endmodule

// File: rtl/irq_msg_gen.sv
module irq_msg_gen #(
   parameter int LOC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LOC_W-1:0] locator_i,
   input  logic             int_dis_i,
   input  logic             msg_en_i,
   output logic             irq_level_o,
   output logic             msg_req_o
);
   logic lvl;
   logic last_q;
   logic req_q;

   assign lvl = !int_dis_i && (locator_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         req_q  <= msg_en_i && (lvl != last_q);
         last_q <= lvl;
      end
   end

   assign irq_level_o = lvl;
   assign msg_req_o   = req_q;

   p_msg_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req_o == ($past(msg_en_i) && ($past(irq_level_o) != $past(irq_level_o, 2))));
   p_msg_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(msg_en_i) |-> !msg_req_o);
endmodule

// File: rtl/slot_irq_locator.sv
module slot_irq_locator
   import slot_irq_pkg::*;
#(
   parameter int NUM_SLOTS = 31,
   parameter int LOC_W     = 32,
   localparam int SLOT_W   = $clog2(LOC_W),
   localparam int EVT_BUS  = NUM_SLOTS * EVT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EVT_BUS-1:0] evt_set_i,
   input  logic               cmd_done_i,
   input  logic               clr_en_i,
   input  logic [SLOT_W-1:0]  clr_slot_i,
   input  logic [EVT_W-1:0]   clr_bits_i,
   input  logic               msk_en_i,
   input  logic [SLOT_W-1:0]  msk_slot_i,
   input  logic [MSK_W-1:0]   msk_data_i,
   input  logic               ctl_en_i,
   input  logic [CTL_W:0]     ctl_data_i,
   input  logic               msg_en_i,
   input  logic [SLOT_W-1:0]  rd_slot_i,
   output logic [EVT_W-1:0]   rd_latch_o,
   output logic [MSK_W-1:0]   rd_mask_o,
   output logic [CTL_W-1:0]   ctl_o,
   output logic [LOC_W-1:0]   locator_o,
   output logic               irq_level_o,
   output logic               msg_req_o
);
   if (NUM_SLOTS < 1 || NUM_SLOTS > LOC_W - 1) begin : g_bad_slots
      $error("slot_irq_locator: NUM_SLOTS must be 1..LOC_W-1");
   end

   logic [EVT_W-1:0] latch_a [NUM_SLOTS];
   logic [MSK_W-1:0] mask_a  [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] pend;
   logic [CTL_W-1:0] ctl_q;
   logic             cmd_flag;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic hit_clr;
      logic hit_msk;
      assign hit_clr = clr_en_i && (clr_slot_i == SLOT_W'(s));
      assign hit_msk = msk_en_i && (msk_slot_i == SLOT_W'(s));
      slot_evt_cell #(
         .EVT_W   (EVT_W),
         .MSK_W   (MSK_W),
         .MSK_RST (MASK_RST)
      ) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_i      (evt_set_i[s*EVT_W +: EVT_W]),
         .clr_en_i   (hit_clr),
         .clr_bits_i (clr_bits_i),
         .msk_en_i   (hit_msk),
         .msk_data_i (msk_data_i),
         .latch_o    (latch_a[s]),
         .mask_o     (mask_a[s]),
         .pend_o     (pend[s])
      );
   end

   cmd_ctl_reg #(
      .CTL_W   (CTL_W),
      .CLR_BIT (CTL_CMD_CLR),
      .CTL_RST (CTL_RST)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_en_i   (ctl_en_i),
      .ctl_data_i (ctl_data_i),
      .cmd_done_i (cmd_done_i),
      .ctl_o      (ctl_q),
      .cmd_flag_o (cmd_flag)
   );

   always_comb begin
      locator_o    = '0;
      locator_o[0] = cmd_flag && !ctl_q[CTL_CMD_DIS];
      for (int s = 0; s < NUM_SLOTS; s++) begin
         locator_o[s+1] = pend[s];
      end
   end

   always_comb begin
      rd_latch_o = '0;
      rd_mask_o  = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (rd_slot_i == SLOT_W'(s)) begin
            rd_latch_o = latch_a[s];
            rd_mask_o  = mask_a[s];
         end
      end
   end

   irq_msg_gen #(
      .LOC_W (LOC_W)
   ) u_msg (
      .clk         (clk),
      .rst_n       (rst_n),
      .locator_i   (locator_o),
      .int_dis_i   (ctl_q[CTL_INT_DIS]),
      .msg_en_i    (msg_en_i),
      .irq_level_o (irq_level_o),
      .msg_req_o   (msg_req_o)
   );

   assign ctl_o = ctl_q;

   p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CTL_INT_DIS] |-> !irq_level_o);
   p_cmd_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CTL_CMD_DIS] || !cmd_flag) |-> !locator_o[0]);
   p_irq_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[CTL_INT_DIS] && cmd_flag && !ctl_q[CTL_CMD_DIS]) |-> irq_level_o);
endmodule

// File: tb/slot_irq_locator_bench.sv
`timescale 1ns/1ps
module slot_irq_locator_bench;
   localparam int NS = 31;
   localparam int LW = 32;
   localparam int SW = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NS*5-1:0] evt_set = '0;
   logic            cmd_done = 1'b0;
   logic            clr_en = 1'b0;
   logic [SW-1:0]   clr_slot = '0;
   logic [4:0]      clr_bits = '0;
   logic            msk_en = 1'b0;
   logic [SW-1:0]   msk_slot = '0;
   logic [7:0]      msk_data = '0;
   logic            ctl_en = 1'b0;
   logic [4:0]      ctl_data = '0;
   logic            msg_en = 1'b0;
   logic [SW-1:0]   rd_slot = '0;
   logic [4:0]      rd_latch;
   logic [7:0]      rd_mask;
   logic [3:0]      ctl_o;
   logic [LW-1:0]   locator;
   logic            irq_level;
   logic            msg_req;

   always #2.5 clk = ~clk;

   slot_irq_locator #(.NUM_SLOTS(NS), .LOC_W(LW)) u_slot_irq_locator (
      .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set), .cmd_done_i(cmd_done),
      .clr_en_i(clr_en), .clr_slot_i(clr_slot), .clr_bits_i(clr_bits),
      .msk_en_i(msk_en), .msk_slot_i(msk_slot), .msk_data_i(msk_data),
      .ctl_en_i(ctl_en), .ctl_data_i(ctl_data), .msg_en_i(msg_en),
      .rd_slot_i(rd_slot), .rd_latch_o(rd_latch), .rd_mask_o(rd_mask),
      .ctl_o(ctl_o), .locator_o(locator), .irq_level_o(irq_level),
      .msg_req_o(msg_req)
   );

   logic [4:0] m_latch [NS];
   logic [7:0] m_mask  [NS];
   logic [3:0] m_ctl;
   logic       m_cmd;
   logic       m_last;
   logic       m_msg;
   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   function automatic logic [LW-1:0] exp_locator();
      logic [LW-1:0] l = '0;
      l[0] = m_cmd && !m_ctl[2];
      for (int s = 0; s < NS; s++) l[s+1] = |(m_latch[s] & ~m_mask[s][4:0]);
      return l;
   endfunction

   function automatic logic exp_level();
      return !m_ctl[0] && (exp_locator() != '0);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < NS; s++) begin
         m_latch[s] = '0;
         m_mask[s]  = 8'h7F;
      end
      m_ctl = 4'hF; m_cmd = 1'b0; m_last = 1'b0; m_msg = 1'b0;
   endtask

   task automatic check_all(input logic [SW-1:0] rs);
      rd_slot = rs;
      #1;
      chk("R5", locator, exp_locator());
      chk("R8", {31'd0, irq_level}, {31'd0, exp_level()});
      chk("R9", {31'd0, msg_req}, {31'd0, m_msg});
      chk("R7", {28'd0, ctl_o}, {28'd0, m_ctl});
      if (rs < NS) begin
         chk("R2", {27'd0, rd_latch}, {27'd0, m_latch[rs]});
         chk("R4", {24'd0, rd_mask}, {24'd0, m_mask[rs]});
      end else begin
         chk("R11", {19'd0, rd_latch, rd_mask}, 32'd0);
      end
   endtask

   task automatic step(input logic [SW-1:0] rs);
      logic lv;
      @(posedge clk);
      lv = exp_level();
      m_msg  = msg_en && (lv != m_last);
      m_last = lv;
      for (int s = 0; s < NS; s++) begin
         if (clr_en && clr_slot == SW'(s)) m_latch[s] = m_latch[s] & ~clr_bits;
         m_latch[s] = m_latch[s] | evt_set[s*5 +: 5];
      end
      if (msk_en && msk_slot < NS) m_mask[msk_slot] = msk_data;
      m_cmd = (m_cmd && !(ctl_en && ctl_data[4])) || cmd_done;
      if (ctl_en) m_ctl = ctl_data[3:0];
      @(negedge clk);
      evt_set = '0; cmd_done = 0; clr_en = 0; msk_en = 0; ctl_en = 0;
      check_all(rs);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      check_all(5'd0);
      chk("R1", locator, 32'd0);
      chk("R1", {27'd0, rd_latch}, 32'd0);
      chk("R1", {24'd0, rd_mask}, 32'h7F);
      chk("R1", {28'd0, ctl_o}, 32'hF);
      rst_n = 1'b1;
      step(5'd0);

      // R2 / R5: event stays masked until the mask opens
      evt_set[0*5+2] = 1'b1; step(5'd0);
      chk("R5", locator, 32'd0);
      msk_en = 1; msk_slot = 0; msk_data = 8'h00; step(5'd0);
      chk("R5", locator, 32'h2);
      chk("R8", {31'd0, irq_level}, 32'd0);
      // R8 / R9: enable interrupt with message mode on
      msg_en = 1; ctl_en = 1; ctl_data = 5'h0; step(5'd0);
      chk("R8", {31'd0, irq_level}, 32'd1);
      step(5'd0);
      chk("R9", {31'd0, msg_req}, 32'd1);
      step(5'd0);
      chk("R9", {31'd0, msg_req}, 32'd0);

      // R3: set and clear of the same bit in one cycle leaves it set
      evt_set[0*5+1] = 1'b1; clr_en = 1; clr_slot = 0; clr_bits = 5'b00110; step(5'd0);
      chk("R3", {27'd0, rd_latch}, 32'h2);
      clr_en = 1; clr_slot = 0; clr_bits = 5'b11111; step(5'd0);
      chk("R3", {27'd0, rd_latch}, 32'h0);

      // R4: mask bits 5 and 6 do not gate the locator
      msk_en = 1; msk_slot = 3; msk_data = 8'h60; step(5'd3);
      evt_set[3*5+4] = 1'b1; step(5'd3);
      chk("R4", locator, 32'h10);
      // R5: highest slot maps to bit NS
      msk_en = 1; msk_slot = NS-1; msk_data = 8'h00; evt_set[(NS-1)*5+0] = 1'b1; step(SW'(NS-1));
      chk("R5", {31'd0, locator[NS]}, 32'd1);

      // R6: command flag and its disable
      clr_en = 1; clr_slot = 3; clr_bits = 5'h1F; step(5'd3);
      clr_en = 1; clr_slot = NS-1; clr_bits = 5'h1F; step(5'd3);
      cmd_done = 1; step(5'd0);
      chk("R6", {31'd0, locator[0]}, 32'd1);
      ctl_en = 1; ctl_data = 5'b00100; step(5'd0);
      chk("R6", {31'd0, locator[0]}, 32'd0);
      ctl_en = 1; ctl_data = 5'b10000; cmd_done = 1; step(5'd0);
      chk("R6", {31'd0, locator[0]}, 32'd1);
      ctl_en = 1; ctl_data = 5'b10000; step(5'd0);
      chk("R6", {31'd0, locator[0]}, 32'd0);

      // R10: level changes with message mode off raise nothing, even later
      msg_en = 0; cmd_done = 1; step(5'd0);
      chk("R10", {31'd0, irq_level}, 32'd1);
      step(5'd0);
      chk("R10", {31'd0, msg_req}, 32'd0);
      msg_en = 1; step(5'd0);
      step(5'd0);
      chk("R10", {31'd0, msg_req}, 32'd0);

      // R11: out-of-range slot writes and reads
      msk_en = 1; msk_slot = 5'd31; msk_data = 8'h00; clr_en = 1; clr_slot = 5'd31; clr_bits = 5'h1F;
      step(5'd31);
      chk("R11", {19'd0, rd_latch, rd_mask}, 32'd0);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         for (int b = 0; b < NS*5; b++) evt_set[b] = ($urandom % 48) == 0;
         cmd_done = ($urandom % 8) == 0;
         clr_en   = ($urandom % 3) == 0;
         clr_slot = SW'($urandom);
         clr_bits = 5'($urandom);
         msk_en   = ($urandom % 4) == 0;
         msk_slot = SW'($urandom);
         msk_data = 8'($urandom);
         ctl_en   = ($urandom % 6) == 0;
         ctl_data = 5'($urandom);
         msg_en   = ($urandom % 4) != 0;
         step(SW'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule